// File: doc/BRIEF.md
# Sensor Row Dark-Level Corrector

This block pulls a full frame from an image sensor over a parallel pixel port with a valid/ready handshake. Each sensor line carries a run of picture pixels followed by a pair of light-shielded reference pixels. The block averages the two reference pixels of a line to get that line's dark-level offset. It subtracts the offset from every picture pixel of the same line, then fetches the next line. The corrected frame is held in an internal buffer.

A host controls the block through a small memory-mapped port. A write to the control address starts a capture. A read of the same address returns a busy flag. Reads in the lower half of the address space return corrected pixels, laid out row-major. The block stages one line in registers while it fetches the line. It then writes the corrected values into the frame buffer one per cycle, and goes back for the next line.

Top module: `row_bias_corrector`

## Requirements
- R1: After reset `pix_ready_o` is 0, and a status read (address bit 12 set) returns 0.
- R2: A write to an address with bit 12 set and `bus_wdata_i` bit 0 equal to 1, made while idle, starts a capture. `pix_ready_o` rises in the next cycle.
- R3: During a capture, a pixel is taken in each cycle where `pix_valid_i` and `pix_ready_o` are both 1. Each line is 66 values: 64 picture pixels in column order, then 2 reference pixels.
- R4: After the 66th pixel of a line is taken, `pix_ready_o` stays 0 for exactly 66 cycles. It then returns to 1 for the next line, or stays 0 after the last line. No buffer write happens while `pix_ready_o` is 1.
- R5: A line's offset is the sum of its two reference pixels divided by 2, truncated.
- R6: Each stored pixel equals the picture pixel minus its line's offset, modulo 256, with no saturation.
- R7: After line 64 the block returns to idle. From the cycle in which `pix_ready_o` would otherwise have risen again, status reads return 0.
- R8: A start write made while busy is ignored. Handshake timing and stored data are the same as without it.
- R9: A read with address bit 12 clear returns the stored pixel at row*64+col on `bus_rdata_o` one cycle after `bus_rd_i`. A status read returns busy in bit 0, with all other bits 0, also one cycle later.
- R10: A control write with `bus_wdata_i` bit 0 equal to 0 does not start a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Sensor pixel value |
| pix_valid_i | input | 1 | Sensor pixel present |
| pix_ready_o | output | 1 | Block takes a pixel this cycle if valid |
| bus_addr_i | input | 13 | Host address; bit 12 selects control/status |
| bus_wr_i | input | 1 | Host write strobe (one cycle) |
| bus_rd_i | input | 1 | Host read strobe (one cycle) |
| bus_wdata_i | input | 8 | Host write data; bit 0 = start |
| bus_rdata_o | output | 8 | Host read data, valid the cycle after a read |

## Verification
The assertions rely on two assumptions about the inputs. The host never asserts read and write in the same cycle. The sensor holds pixel data stable only for the cycle in which it is taken, so nothing else is assumed about `pix_i`. The bench drives the host strobes from a single sequential thread, one strobe per access, which keeps read and write apart. It feeds the sensor port both with back-to-back pixels and with random idle gaps. Corner lines cover a 255/254 reference pair (truncated offset 254), a zero offset, and a small offset applied to a zero pixel, which must wrap to 255.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GET  = 3'd1,
    ST_BIAS = 3'd2,
    ST_FIX  = 3'd3,
    ST_NEXT = 3'd4
  } state_e;
endpackage

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int REFS = 2,
  localparam int LINE = COLS + REFS,
  localparam int CW = $clog2(LINE),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          pix_valid_i,
  output state_e        state_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          pix_ready_o,
  output logic          busy_o
);
  state_e        state_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          take;

  assign take        = (state_q == ST_GET) && pix_valid_i;
  assign pix_ready_o = (state_q == ST_GET);
  assign busy_o      = (state_q != ST_IDLE);
  assign state_o     = state_q;
  assign row_o       = row_q;
  assign col_o       = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          row_q <= '0;
          col_q <= '0;
          if (start_i) state_q <= ST_GET;
        end
        ST_GET: if (take) begin
          if (col_q == CW'(LINE - 1)) state_q <= ST_BIAS;
          else col_q <= col_q + 1'b1;
        end
        ST_BIAS: begin
          col_q   <= '0;
          state_q <= ST_FIX;
        end
        ST_FIX: begin
          if (col_q == CW'(COLS - 1)) state_q <= ST_NEXT;
          else col_q <= col_q + 1'b1;
        end
        ST_NEXT: begin
          col_q <= '0;
          if (row_q == RW'(ROWS - 1)) begin
            row_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            row_q   <= row_q + 1'b1;
            state_q <= ST_GET;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  col_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= CW'(LINE - 1));

  // R4
  line_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && col_q == CW'(LINE - 1)) |=> !pix_ready_o);
endmodule

// File: rtl/rbc_row_store.sv
module rbc_row_store
  import rbc_pkg::*;
#(
  parameter int PW   = 8,
  parameter int COLS = 64,
  parameter int REFS = 2,
  localparam int LINE = COLS + REFS,
  localparam int CW = $clog2(LINE),
  localparam int SW = PW + $clog2(REFS) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  state_e        state_i,
  input  logic          take_i,
  input  logic [CW-1:0] col_i,
  input  logic [PW-1:0] pix_i,
  output logic [PW-1:0] fixed_o
);
  logic [PW-1:0] line_q [LINE];
  logic [PW-1:0] bias_q;
  logic [SW-1:0] ref_sum;
  logic [PW-1:0] ref_min, ref_max;

  always_ff @(posedge clk_i) begin
    if (take_i) line_q[col_i] <= pix_i;
  end

  always_comb begin
    ref_sum = '0;
    ref_min = '1;
    ref_max = '0;
    for (int i = COLS; i < LINE; i++) begin
      ref_sum = ref_sum + SW'(line_q[i]);
      if (line_q[i] < ref_min) ref_min = line_q[i];
      if (line_q[i] > ref_max) ref_max = line_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bias_q <= '0;
    else if (state_i == ST_BIAS) bias_q <= PW'(ref_sum / SW'(REFS));
  end

  // modulo-2^PW subtraction, no clamp
  assign fixed_o = line_q[col_i] - bias_q;

  // R5
  bias_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FIX) |-> (bias_q >= ref_min && bias_q <= ref_max));
endmodule

// File: rtl/rbc_frame_buf.sv
module rbc_frame_buf #(
  parameter int PW    = 8,
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [PW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [PW-1:0] rdata_o
);
  logic [PW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/row_bias_corrector.sv
module row_bias_corrector
  import rbc_pkg::*;
#(
  parameter int PW   = 8,
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int REFS = 2,
  localparam int LINE  = COLS + REFS,
  localparam int DEPTH = ROWS * COLS,
  localparam int MAW   = $clog2(DEPTH),
  localparam int BAW   = MAW + 1,
  localparam int CW    = $clog2(LINE),
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [PW-1:0]  pix_i,
  input  logic           pix_valid_i,
  output logic           pix_ready_o,
  input  logic [BAW-1:0] bus_addr_i,
  input  logic           bus_wr_i,
  input  logic           bus_rd_i,
  input  logic [PW-1:0]  bus_wdata_i,
  output logic [PW-1:0]  bus_rdata_o
);
  state_e        state;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          busy, start_cmd, take, mem_we;
  logic [PW-1:0] fixed, mem_rdata;
  logic [MAW-1:0] waddr;
  logic          sel_ctrl_q, stat_q;

  assign start_cmd = bus_wr_i && bus_addr_i[BAW-1] && bus_wdata_i[0];
  assign take      = pix_valid_i && pix_ready_o;
  assign mem_we    = (state == ST_FIX);
  assign waddr     = MAW'(row) * MAW'(COLS) + MAW'(col);

  rbc_ctrl #(.ROWS(ROWS), .COLS(COLS), .REFS(REFS)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i     (start_cmd),
    .pix_valid_i,
    .state_o     (state),
    .row_o       (row),
    .col_o       (col),
    .pix_ready_o,
    .busy_o      (busy)
  );

  rbc_row_store #(.PW(PW), .COLS(COLS), .REFS(REFS)) u_line (
    .clk_i, .rst_ni,
    .state_i (state),
    .take_i  (take),
    .col_i   (col),
    .pix_i,
    .fixed_o (fixed)
  );

  rbc_frame_buf #(.PW(PW), .DEPTH(DEPTH)) u_frame (
    .clk_i, .rst_ni,
    .we_i    (mem_we),
    .waddr_i (waddr),
    .wdata_i (fixed),
    .re_i    (bus_rd_i && !bus_addr_i[BAW-1]),
    .raddr_i (bus_addr_i[MAW-1:0]),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_ctrl_q <= 1'b0;
      stat_q     <= 1'b0;
    end else if (bus_rd_i) begin
      sel_ctrl_q <= bus_addr_i[BAW-1];
      stat_q     <= busy;
    end
  end

  assign bus_rdata_o = sel_ctrl_q ? {{(PW-1){1'b0}}, stat_q} : mem_rdata;

  // R4
  no_wr_during_get_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !pix_ready_o);

  // R8
  restart_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_cmd && state == ST_GET) |=> (pix_ready_o || state == ST_BIAS));

  // R2
  start_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_cmd) |=> pix_ready_o);
endmodule

// File: tb/sim_row_bias_corrector.sv
module sim_row_bias_corrector;
  localparam int N_PIX = 64 * 66;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pix = '0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [12:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0, errors = 0, cycles = 0;

  logic [7:0] img [N_PIX];
  logic [7:0] exp_img [4096];

  // model state
  bit m_busy = 0, m_ready = 0;
  int m_row = 0, m_cnt = 0, m_gap = 0;
  int k = 0, base = 0;
  bit feed = 0, gaps = 0;

  row_bias_corrector u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pix_valid_i(pix_valid),
    .pix_ready_o(pix_ready), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // reference model, advanced on each edge
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (pix_valid && m_ready) k <= k + 1;
      if (!m_busy) begin
        if (wr && addr[12] && wdata[0]) begin
          m_busy <= 1; m_ready <= 1; m_row <= 0; m_cnt <= 0;
        end
      end else if (m_ready) begin
        if (pix_valid) begin
          if (m_cnt == 65) begin m_ready <= 0; m_gap <= 66; end
          else m_cnt <= m_cnt + 1;
        end
      end else if (m_gap == 1) begin
        m_gap <= 0;
        if (m_row == 63) m_busy <= 0;
        else begin m_row <= m_row + 1; m_cnt <= 0; m_ready <= 1; end
      end else m_gap <= m_gap - 1;
    end
  end

  // per-clock comparison and stimulus drive
  always @(negedge clk) begin
    if (rst_n) chk(pix_ready === m_ready, "R3/R4 ready", int'(pix_ready), int'(m_ready));
    pix_valid <= feed && (k - base) < N_PIX && (gaps ? ($urandom_range(0, 2) != 0) : 1'b1);
    pix <= ((k - base) < N_PIX && (k - base) >= 0) ? img[k - base] : 8'h00;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_write(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic build(input int seed_mode);
    for (int r = 0; r < 64; r++) begin
      for (int c = 0; c < 66; c++) img[r*66+c] = 8'($urandom);
      if (seed_mode == 0) begin
        if (r == 0) begin img[64] = 8'd255; img[65] = 8'd254; end
        if (r == 1) begin img[66+64] = 8'd0; img[66+65] = 8'd0; end
        if (r == 2) begin img[132+64] = 8'd3; img[132+65] = 8'd0; img[132] = 8'd0; end
      end
    end
    for (int r = 0; r < 64; r++) begin
      int b;
      b = (int'(img[r*66+64]) + int'(img[r*66+65])) / 2;
      for (int c = 0; c < 64; c++) exp_img[r*64+c] = 8'(int'(img[r*66+c]) - b);
    end
  endtask

  task automatic run_frame(input bit with_gaps, input bit restart);
    logic [7:0] d;
    base = k; gaps = with_gaps; feed = 1;
    bus_write(13'h1000, 8'h01);
    chk(m_busy, "R2 start", int'(m_busy), 1);
    repeat (300) @(negedge clk);
    bus_read(13'h1000, d);
    chk(d == 8'h01, "R9 status busy", d, 1);
    if (restart) begin
      bus_write(13'h1000, 8'h01); // R8
      repeat (500) @(negedge clk);
      bus_write(13'h1000, 8'h01);
    end
    while (m_busy) @(negedge clk);
    feed = 0;
    chk((k - base) == N_PIX, "R3 count", k - base, N_PIX);
    bus_read(13'h1000, d);
    chk(d == 8'h00, "R7 idle status", d, 0);
    for (int a = 0; a < 4096; a++) begin
      bus_read(13'(a), d);
      chk(d === exp_img[a], (a < 192) ? "R5/R6 corner row" : "R6/R9 pixel", d, exp_img[a]);
    end
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_ready == 1'b0, "R1 ready", pix_ready, 0);
    bus_read(13'h1000, d);
    chk(d == 8'h00, "R1 status", d, 0);
    bus_write(13'h1000, 8'h02); // R10
    repeat (5) @(negedge clk);
    chk(!m_busy && !pix_ready, "R10 no start", pix_ready, 0);
    build(0);
    run_frame(1'b0, 1'b1);
    chk(exp_img[0] == 8'(int'(img[0]) - 254), "R5 trunc", exp_img[0], 8'(int'(img[0]) - 254));
    build(1);
    run_frame(1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule